// File: doc/BRIEF.md
# Multi-Level Bus Grant Arbiter

This block decides which master may take a shared system bus next. Four numbered device request lines, levels 4 through 7, compete with one direct-memory request, which outranks all of them. Every clock edge the arbiter looks at the requests and returns at most one grant. It only does so when the bus is quiet, meaning no selection acknowledge and no bus-busy are active.

A granted master replies with a selection acknowledge. The arbiter then drops the grant. The master holds bus-busy while it uses the data section, and the arbiter starts no new grant until both the acknowledge and busy have gone away.

A processor-level input masks the numbered requests at or below that level. A system-initialize line clears all arbitration state. Requests, acknowledge, busy and initialize are active low. Grants are active high.

Top module: `bus_grant_arbiter`

## Requirements
- R1: When `dma_req_n` is low and the bus is quiet, `dma_grant` goes high at the next clock edge, whatever the device requests and `cpu_level` are.
- R2: At most one of the five grant outputs is high in any cycle.
- R3: When no DMA request is present, the highest unmasked device level wins. `dev_req_n[i]` is level 4+i, so bit 3 (level 7) ranks first and bit 0 (level 4) ranks last. The winning level's bit of `dev_grant` rises at the next clock edge.
- R4: A grant stays high, unchanged, while `sel_ack_n` is high and its request is held. On the first edge at which `sel_ack_n` is sampled low, the grant falls.
- R5: While no grant is out, no new grant is issued at any edge where `sel_ack_n` or `bus_busy_n` is sampled low.
- R6: An edge with `init_n` sampled low clears every grant. No grant is issued at that edge.
- R7: If the granted request line goes high before any acknowledge, the grant falls at the next edge. A fresh arbitration follows at the edge after that.
- R8: Device level L is eligible only when L is greater than `cpu_level`. DMA is never masked. When nothing is eligible, no grant is issued.
- R9: While `rst_n` is low, and for the two edges after it is released, all grants are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low, released synchronously inside |
| init_n | input | 1 | System initialize, active low, sampled on the clock |
| dev_req_n | input | 4 | Device requests, active low; bit i is level 4+i |
| dma_req_n | input | 1 | Direct-memory request, active low, highest rank |
| sel_ack_n | input | 1 | Selection acknowledge from the granted master, active low |
| bus_busy_n | input | 1 | Data section in use, active low |
| cpu_level | input | 3 | Processor priority; device levels at or below it are masked |
| dev_grant | output | 4 | Device grants, active high, bit i for level 4+i |
| dma_grant | output | 1 | Direct-memory grant, active high |

## Verification
Every grant result is registered once, so its effect is due exactly one clock edge after the inputs that cause it. This holds for a new grant, a drop on acknowledge, a drop on withdrawal and a clear on initialize. The bench changes inputs just after the falling edge and updates its own model of the grant at each rising edge. It compares the outputs at the following falling edge, which is one edge after the stimulus. After reset is released, stimulus waits until the two synchronizer edges have passed.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_OFFER = 1'b1
  } arb_state_e;
endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/arb_req_cond.sv
module arb_req_cond #(
  parameter int NUM_LVL = 4,
  parameter int LOW_LVL = 4,
  parameter int PRI_W   = 3
) (
  input  logic [NUM_LVL-1:0] dev_req_n,
  input  logic               dma_req_n,
  input  logic [PRI_W-1:0]   cpu_level,
  output logic [NUM_LVL:0]   raw_act,
  output logic [NUM_LVL:0]   elig
);
  // bit NUM_LVL is the DMA request, lower bits are numbered device levels
  assign raw_act[NUM_LVL] = ~dma_req_n;
  assign elig[NUM_LVL]    = ~dma_req_n;

  for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
    localparam logic [PRI_W:0] LVL_V = (PRI_W+1)'(LOW_LVL + i);
    assign raw_act[i] = ~dev_req_n[i];
    assign elig[i]    = ~dev_req_n[i] && (LVL_V > {1'b0, cpu_level});
  end
endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int NUM_LVL = 4
) (
  input  logic [NUM_LVL:0] elig,
  output logic [NUM_LVL:0] win
);
  logic found;

  always_comb begin
    win   = '0;
    found = 1'b0;
    for (int i = NUM_LVL; i >= 0; i--) begin
      if (elig[i] && !found) begin
        win[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_grant_fsm.sv
module arb_grant_fsm
  import arb_pkg::*;
#(
  parameter int NUM_LVL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_n,
  input  logic             sel_ack_n,
  input  logic             bus_busy_n,
  input  logic [NUM_LVL:0] raw_act,
  input  logic [NUM_LVL:0] win,
  output logic [NUM_LVL:0] grant
);
  arb_state_e       state_q, state_d;
  logic [NUM_LVL:0] grant_q, grant_d;
  logic             bus_quiet;
  logic             held;
  logic             upd_en;

  assign bus_quiet = sel_ack_n && bus_busy_n;
  assign held      = |(grant_q & raw_act);

  always_comb begin
    state_d = state_q;
    grant_d = grant_q;
    if (!init_n) begin
      state_d = ST_IDLE;
      grant_d = '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (bus_quiet && (|win)) begin
            state_d = ST_OFFER;
            grant_d = win;
          end
        end
        ST_OFFER: begin
          if (!sel_ack_n || !held) begin
            state_d = ST_IDLE;
            grant_d = '0;
          end
        end
        default: begin
          state_d = ST_IDLE;
          grant_d = '0;
        end
      endcase
    end
  end

  assign upd_en = (state_d != state_q) || (grant_d != grant_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      grant_q <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      grant_q <= grant_d;
    end
  end

  assign grant = grant_q;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q)); // R2
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_q != '0) && !sel_ack_n) |=> (grant_q == '0)); // R4
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_q != '0) && sel_ack_n && init_n && ((grant_q & raw_act) != '0)) |=> $stable(grant_q)); // R4
  AST_QUIET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_q == '0) && (!sel_ack_n || !bus_busy_n)) |=> (grant_q == '0)); // R5
  AST_INIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !init_n |=> (grant_q == '0)); // R6
  AST_WITHDRAW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_q != '0) && ((grant_q & raw_act) == '0)) |=> (grant_q == '0)); // R7
  AST_DMA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_q == '0) && init_n && bus_quiet && raw_act[NUM_LVL]) |=> grant_q[NUM_LVL]); // R1
endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter #(
  parameter int NUM_LVL = 4,
  parameter int LOW_LVL = 4,
  parameter int PRI_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_n,
  input  logic [NUM_LVL-1:0] dev_req_n,
  input  logic               dma_req_n,
  input  logic               sel_ack_n,
  input  logic               bus_busy_n,
  input  logic [PRI_W-1:0]   cpu_level,
  output logic [NUM_LVL-1:0] dev_grant,
  output logic               dma_grant
);
  localparam int VEC_W = NUM_LVL + 1;

  logic             rst_sync_n;
  logic [VEC_W-1:0] raw_act;
  logic [VEC_W-1:0] elig;
  logic [VEC_W-1:0] win;
  logic [VEC_W-1:0] grant;

  arb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  arb_req_cond #(.NUM_LVL(NUM_LVL), .LOW_LVL(LOW_LVL), .PRI_W(PRI_W)) u_cond (
    .dev_req_n (dev_req_n),
    .dma_req_n (dma_req_n),
    .cpu_level (cpu_level),
    .raw_act   (raw_act),
    .elig      (elig)
  );

  arb_prio_pick #(.NUM_LVL(NUM_LVL)) u_pick (
    .elig (elig),
    .win  (win)
  );

  arb_grant_fsm #(.NUM_LVL(NUM_LVL)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .init_n     (init_n),
    .sel_ack_n  (sel_ack_n),
    .bus_busy_n (bus_busy_n),
    .raw_act    (raw_act),
    .win        (win),
    .grant      (grant)
  );

  assign dev_grant = grant[NUM_LVL-1:0];
  assign dma_grant = grant[NUM_LVL];

  AST_MASK_RESPECTED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(dev_grant[0]) |-> ($past(cpu_level) < 3'd4))); // R8
endmodule

// File: tb/bus_grant_arbiter_test.sv
module bus_grant_arbiter_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init_n = 1'b1;
  logic [3:0] dev_req_n = 4'hF;
  logic       dma_req_n = 1'b1;
  logic       sel_ack_n = 1'b1;
  logic       bus_busy_n = 1'b1;
  logic [2:0] cpu_level = 3'd0;
  logic [3:0] dev_grant;
  logic       dma_grant;

  int    n_chk = 0;
  int    n_err = 0;
  bit    chk_on = 1'b0;
  bit    done = 1'b0;
  logic [4:0] exp_g = 5'd0;
  string exp_tag = "R9";

  bus_grant_arbiter uut (
    .clk(clk), .rst_n(rst_n), .init_n(init_n), .dev_req_n(dev_req_n),
    .dma_req_n(dma_req_n), .sel_ack_n(sel_ack_n), .bus_busy_n(bus_busy_n),
    .cpu_level(cpu_level), .dev_grant(dev_grant), .dma_grant(dma_grant)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model of the grant register, from the requirements
  always @(posedge clk) begin
    logic [4:0] act;
    logic [4:0] nxt;
    string      tg;
    act = {~dma_req_n, ~dev_req_n};
    nxt = exp_g;
    tg  = "R4";
    if (!rst_n || !chk_on) begin
      nxt = 5'd0; tg = "R9";
    end else if (!init_n) begin
      nxt = 5'd0; tg = "R6";
    end else if (exp_g != 5'd0) begin
      if (!sel_ack_n)                  begin nxt = 5'd0; tg = "R4"; end
      else if ((exp_g & act) == 5'd0)  begin nxt = 5'd0; tg = "R7"; end
      else                             begin tg = "R4"; end
    end else if (!sel_ack_n || !bus_busy_n) begin
      nxt = 5'd0; tg = "R5";
    end else if (act[4]) begin
      nxt = 5'b10000; tg = "R1";
    end else begin
      nxt = 5'd0; tg = "R8";
      for (int lv = 3; lv >= 0; lv--) begin
        if (nxt == 5'd0 && act[lv] && (lv + 4 > int'(cpu_level))) begin
          nxt = 5'd1 << lv; tg = "R3";
        end
      end
    end
    exp_g   = nxt;
    exp_tag = tg;
  end

  always @(negedge clk) begin
    if (chk_on) begin
      n_chk++;
      if ({dma_grant, dev_grant} !== exp_g) begin
        n_err++;
        $display("FAIL %s: grant=%b expected=%b at %0t", exp_tag, {dma_grant, dev_grant}, exp_g, $time);
      end
      n_chk++;
      if ($countones({dma_grant, dev_grant}) > 1) begin
        n_err++;
        $display("FAIL R2: grant=%b expected at most one bit set", {dma_grant, dev_grant});
      end
    end
  end

  task automatic drive(input logic [3:0] dv, input logic dm, input logic sk,
                       input logic bz, input logic it, input logic [2:0] cp);
    @(negedge clk);
    #1;
    dev_req_n = dv; dma_req_n = dm; sel_ack_n = sk;
    bus_busy_n = bz; init_n = it; cpu_level = cp;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if ({dma_grant, dev_grant} !== 5'd0) begin
      n_err++;
      $display("FAIL R9: grant=%b expected=00000 in reset", {dma_grant, dev_grant});
    end
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if ({dma_grant, dev_grant} !== 5'd0) begin
      n_err++;
      $display("FAIL R9: grant=%b expected=00000 after reset", {dma_grant, dev_grant});
    end
    chk_on = 1'b1;

    // R3: levels 4 and 6 requested, level 6 wins
    drive(4'b1010, 1, 1, 1, 1, 3'd0);
    drive(4'b1010, 1, 1, 1, 1, 3'd0);
    // R4: acknowledge drops the grant; R5: level 7 waits while ack/busy held
    drive(4'b0010, 1, 0, 0, 1, 3'd0);
    drive(4'b0010, 1, 0, 0, 1, 3'd0);
    drive(4'b0010, 1, 1, 0, 1, 3'd0);
    drive(4'b0010, 1, 1, 1, 1, 3'd0);
    drive(4'b1111, 1, 0, 1, 1, 3'd0);
    drive(4'b1111, 1, 1, 1, 1, 3'd0);
    // R1: DMA beats every level, even with cpu level 7
    drive(4'b0000, 0, 1, 1, 1, 3'd7);
    drive(4'b0000, 0, 0, 0, 1, 3'd7);
    drive(4'b1111, 1, 1, 1, 1, 3'd7);
    // R8: levels 4 and 5 masked at cpu level 5, level 6 passes
    drive(4'b1100, 1, 1, 1, 1, 3'd5);
    drive(4'b1100, 1, 1, 1, 1, 3'd5);
    drive(4'b1000, 1, 1, 1, 1, 3'd5);
    // R7: withdrawal before acknowledge, then re-arbitration
    drive(4'b1111, 1, 1, 1, 1, 3'd5);
    drive(4'b1110, 1, 1, 1, 1, 3'd0);
    drive(4'b1110, 1, 1, 1, 1, 3'd0);
    // R6: initialize clears and blocks
    drive(4'b0000, 0, 1, 1, 0, 3'd0);
    drive(4'b0000, 0, 1, 1, 0, 3'd0);
    drive(4'b1111, 1, 1, 1, 1, 3'd0);
    drive(4'b1111, 1, 1, 1, 1, 3'd0);

    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] dv;
      for (int b = 0; b < 4; b++) dv[b] = ($urandom % 100) >= 40;
      drive(dv, ($urandom % 100) >= 15, ($urandom % 100) >= 25,
            ($urandom % 100) >= 20, ($urandom % 100) >= 3, 3'($urandom % 8));
    end

    drive(4'b1111, 1, 1, 1, 1, 3'd0);
    drive(4'b1111, 1, 1, 1, 1, 3'd0);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule